// File: doc/BRIEF.md
# Dual-Mode Real-Time Clock Alarm Comparator

This block watches the live count of a real-time clock and raises an alarm interrupt flag once the count reaches a programmed alarm. It has two modes, picked by a mode pin. In calendar mode there are seven time fields: second, minute, hour, weekday, day, month and year. Each field has its own alarm value and its own enable, and only the enabled fields must agree with the counter. In binary mode a 32-bit free-running counter is compared with a 32-bit alarm value under a per-bit mask.

Both modes share a bank of eight byte-wide registers, and the active mode decides what each byte means. Software programs the bank through a plain write/read port. The counter logic sits outside this block; it supplies the counter values and a tick strobe each time the count advances. The match is evaluated only on a tick. The flag is set when a match begins and stays set until software clears it. A software-reset pin returns the whole bank to zero. After a power-on reset and before any software reset, the bank contents are undefined; in simulation they are left as X.

Register bank layout, by byte address:

| Address | Calendar mode | Binary mode |
|---|---|---|
| 0 to 5 | second, minute, hour, weekday, day, month: bit 7 is the enable, bits 6..0 the alarm value | 0 to 3: alarm bytes, byte 0 holds bits 7..0; 4 and 5: mask bytes 0 and 1 |
| 6 | year alarm value, all 8 bits | mask byte 2 (bits 23..16) |
| 7 | bit 7 enables the year compare; bits 6..0 are reserved, written 0, read back as written | mask byte 3 (bits 31..24) |

All ports are plain control pins. None of them carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rtcalm_cmp`

## Requirements
- R1: In calendar mode (mode=0), a tick on which every enabled field equals its counter, with at least one enable set, sets irq_flag in the following cycle.
- R2: In calendar mode, a field whose enable bit (bit 7 of addresses 0 to 5, or bit 7 of address 7 for the year) is 0 takes no part in the match, whatever its counter value.
- R3: In binary mode (mode=1), the alarm is {addr3,addr2,addr1,addr0} and the mask is {addr7,addr6,addr5,addr4}. A tick on which every masked bit of bin_cnt equals the alarm bit, with a nonzero mask, sets irq_flag in the following cycle.
- R4: In binary mode, bin_cnt bits whose mask bit is 0 have no effect on the match.
- R5: Address 7 holds the year enable in calendar mode and mask bits 31..24 in binary mode. The same stored byte gives each meaning according to the mode.
- R6: A software reset (sw_rst=1 at a clock edge) sets all eight registers to 00h, which rd_data then shows.
- R7: A write stores all 8 bits of wr_data at addr, reserved bits of address 7 included, and rd_data returns the stored byte combinationally for the current addr.
- R8: The flag is set only when the match begins: a tick whose match also held on the previous tick does not set it again. A match that drops on one tick and returns on a later tick sets it again.
- R9: irq_flag stays 1 until irq_clr=1 at a clock edge clears it. When a set and a clear fall in the same cycle, the set wins.
- R10: When the active mode has no enable bit set, irq_flag is never set.
- R11: With rst_n low, irq_flag is 0.
- R12: The match is evaluated only in cycles with tick=1. A matching count with no tick leaves irq_flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the flag and match history |
| sw_rst | input | 1 | Synchronous software reset: clears the register bank and the match history |
| mode | input | 1 | 0 = calendar compare, 1 = binary compare |
| wr_en | input | 1 | Write strobe for the register bank |
| addr | input | 3 | Register byte address for both write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the register at addr |
| tick | input | 1 | Strobe that marks a counter update |
| cal_sec | input | 7 | Seconds counter |
| cal_min | input | 7 | Minutes counter |
| cal_hour | input | 7 | Hours counter |
| cal_wday | input | 7 | Weekday counter |
| cal_day | input | 7 | Day-of-month counter |
| cal_mon | input | 7 | Month counter |
| cal_year | input | 8 | Year counter |
| bin_cnt | input | 32 | Binary free-running counter |
| irq_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_flag | output | 1 | Sticky alarm interrupt flag |

## Verification
The calendar sweep runs through all 128 combinations of the seven field enables. For each combination it tries counters that match exactly and counters that differ in one field, for every field in turn. This tells apart a field that is really excluded from one that is still compared. The binary sweep pairs single-bit masks, whole-byte masks, a full mask, a checkerboard mask and an empty mask with a counter that has one of its 32 bits flipped, or none. This shows that each mask bit gates exactly its own bit position and that each mask byte sits in the right place. Directed sequences cover how the shared address 7 reads in each mode, a match held over several ticks, a match that drops and comes back, a clear that lands on the same cycle as a set, and matching counts that arrive with no tick.

// File: rtl/rtcalm_pkg.sv
package rtcalm_pkg;
  typedef enum logic {MODE_CAL = 1'b0, MODE_BIN = 1'b1} mode_e;
  // Bytes of the binary alarm value (and of its mask)
  localparam int unsigned BIN_BYTES = 4;
  // Registers in the shared bank: alarm bytes plus mask bytes
  localparam int unsigned NREG      = 2 * BIN_BYTES;
  localparam int unsigned ADDR_W    = $clog2(NREG);
  // Calendar fields that carry an inline enable bit (all but the year)
  localparam int unsigned NFIELD    = NREG - 2;
  localparam int unsigned YR_VAL    = NREG - 2;
  localparam int unsigned YR_EN     = NREG - 1;
endpackage

// File: rtl/rtcalm_regs.sv
module rtcalm_regs
  import rtcalm_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sw_rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wr_data,
  output logic [NREG-1:0][REG_W-1:0]  regs_q,
  output logic [REG_W-1:0]            rd_data
);
  // No power-on reset: contents stay undefined until a software reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (sw_rst) begin
        regs_q[i] <= '0;
      end else if (wr_en && (addr == ADDR_W'(i))) begin
        regs_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = regs_q[addr];

  // R6
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (rd_data == '0));

  // R7
  write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sw_rst) |=> (regs_q[$past(addr)] == $past(wr_data)));
endmodule

// File: rtl/rtcalm_match.sv
module rtcalm_match
  import rtcalm_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  mode_e                            mode_sel,
  input  logic [NREG-1:0][REG_W-1:0]       regs,
  input  logic [NFIELD-1:0][REG_W-2:0]     cal_cnt,
  input  logic [REG_W-1:0]                 cal_year,
  input  logic [REG_W*BIN_BYTES-1:0]       bin_cnt,
  output logic                             hit,
  output logic                             any_en
);
  localparam int unsigned FW    = REG_W - 1;
  localparam int unsigned BIN_W = REG_W * BIN_BYTES;

  // Calendar compare: one enable per field
  logic [NFIELD-1:0] fld_en;
  logic [NFIELD-1:0] fld_ok;
  logic              yr_en;
  logic              yr_ok;
  logic              cal_any;
  logic              cal_hit;

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    assign fld_en[f] = regs[f][REG_W-1];
    assign fld_ok[f] = !fld_en[f] || (regs[f][FW-1:0] == cal_cnt[f]);
  end

  assign yr_en   = regs[YR_EN][REG_W-1];
  assign yr_ok   = !yr_en || (regs[YR_VAL] == cal_year);
  assign cal_any = (|fld_en) || yr_en;
  assign cal_hit = cal_any && (&fld_ok) && yr_ok;

  // Binary compare: per-bit mask
  logic [BIN_W-1:0] bin_alarm;
  logic [BIN_W-1:0] bin_mask;
  logic             bin_any;
  logic             bin_hit;

  for (genvar b = 0; b < BIN_BYTES; b++) begin : g_byte
    assign bin_alarm[b*REG_W +: REG_W] = regs[b];
    assign bin_mask[b*REG_W +: REG_W]  = regs[BIN_BYTES + b];
  end

  assign bin_any = |bin_mask;
  assign bin_hit = bin_any && (((bin_cnt ^ bin_alarm) & bin_mask) == '0);

  always_comb begin
    if (mode_sel == MODE_BIN) begin
      hit    = bin_hit;
      any_en = bin_any;
    end else begin
      hit    = cal_hit;
      any_en = cal_any;
    end
  end
endmodule

// File: rtl/rtcalm_flag.sv
module rtcalm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic tick,
  input  logic hit,
  input  logic irq_clr,
  output logic irq_flag
);
  logic prev_q;
  logic set_now;

  // Match seen on the previous tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (sw_rst) begin
      prev_q <= 1'b0;
    end else if (tick) begin
      prev_q <= hit;
    end
  end

  assign set_now = tick && hit && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
    end else if (set_now) begin
      irq_flag <= 1'b1;
    end else if (irq_clr) begin
      irq_flag <= 1'b0;
    end
  end

  // R1
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(tick && hit));

  // R8
  held_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && prev_q && !irq_flag) |=> !irq_flag);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && !prev_q && irq_clr) |=> irq_flag);

  // R12
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !irq_flag) |=> !irq_flag);
endmodule

// File: rtl/rtcalm_cmp.sv
module rtcalm_cmp
  import rtcalm_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_rst,
  input  logic                       mode,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wr_data,
  output logic [REG_W-1:0]           rd_data,
  input  logic                       tick,
  input  logic [REG_W-2:0]           cal_sec,
  input  logic [REG_W-2:0]           cal_min,
  input  logic [REG_W-2:0]           cal_hour,
  input  logic [REG_W-2:0]           cal_wday,
  input  logic [REG_W-2:0]           cal_day,
  input  logic [REG_W-2:0]           cal_mon,
  input  logic [REG_W-1:0]           cal_year,
  input  logic [REG_W*BIN_BYTES-1:0] bin_cnt,
  input  logic                       irq_clr,
  output logic                       irq_flag
);
  logic [NREG-1:0][REG_W-1:0]   regs_q;
  logic [NFIELD-1:0][REG_W-2:0] cal_cnt;
  mode_e                        mode_sel;
  logic                         hit;
  logic                         any_en;

  assign mode_sel = mode_e'(mode);
  // Field order follows the register addresses 0..5
  assign cal_cnt  = {cal_mon, cal_day, cal_wday, cal_hour, cal_min, cal_sec};

  rtcalm_regs #(.REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_rst  (sw_rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .regs_q  (regs_q),
    .rd_data (rd_data)
  );

  rtcalm_match #(.REG_W(REG_W)) u_match (
    .mode_sel (mode_sel),
    .regs     (regs_q),
    .cal_cnt  (cal_cnt),
    .cal_year (cal_year),
    .bin_cnt  (bin_cnt),
    .hit      (hit),
    .any_en   (any_en)
  );

  rtcalm_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .tick     (tick),
    .hit      (hit),
    .irq_clr  (irq_clr),
    .irq_flag (irq_flag)
  );

  // R10
  empty_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_en && !irq_flag) |=> !irq_flag);

  // R11
  reset_flag_chk: assert property (@(posedge clk)
    !rst_n |-> !irq_flag);
endmodule

// File: tb/test_rtcalm_cmp.sv
`timescale 1ns/1ps
module test_rtcalm_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        tick = 1'b0;
  logic [6:0]  cal_sec = '0, cal_min = '0, cal_hour = '0;
  logic [6:0]  cal_wday = '0, cal_day = '0, cal_mon = '0;
  logic [7:0]  cal_year = '0;
  logic [31:0] bin_cnt = '0;
  logic        irq_clr = 1'b0;
  logic        irq_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtcalm_cmp i_rtcalm_cmp (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mode(mode),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .tick(tick), .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_wday(cal_wday), .cal_day(cal_day), .cal_mon(cal_mon),
    .cal_year(cal_year), .bin_cnt(bin_cnt), .irq_clr(irq_clr),
    .irq_flag(irq_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    check(tag, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic swr_clr();
    @(negedge clk); sw_rst = 1'b1; irq_clr = 1'b1;
    @(negedge clk); sw_rst = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic do_tick(input bit with_clr);
    @(negedge clk); tick = 1'b1; irq_clr = with_clr;
    @(negedge clk); tick = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    logic [6:0] v [6];
    logic [7:0] yv;
    logic [31:0] msk, alm;
    bit exp;
    string tag;

    idle(3);
    // R11: flag low under and right after power-on reset
    #1 check("R11", {31'h0, irq_flag}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check("R11", {31'h0, irq_flag}, 32'h0);

    // R6: fill, then software reset, read back zeros
    swr_clr();
    for (int a = 0; a < 8; a++) wr(3'(a), 8'hFF);
    swr_clr();
    for (int a = 0; a < 8; a++) rd_check("R6", 3'(a), 8'h00);

    // R7: write/read every address with several patterns, reserved bits kept
    for (int a = 0; a < 8; a++) begin
      wr(3'(a), 8'h5A); rd_check("R7", 3'(a), 8'h5A);
      wr(3'(a), 8'hA5 ^ 8'(a)); rd_check("R7", 3'(a), 8'hA5 ^ 8'(a));
    end
    wr(3'd7, 8'h7F); rd_check("R7", 3'd7, 8'h7F);

    // Calendar sweep: all enable sets, each field mismatched in turn (R1, R2, R10)
    mode = 1'b0;
    for (int e = 0; e < 128; e++) begin
      for (int d = 0; d < 8; d++) begin
        swr_clr();
        for (int f = 0; f < 6; f++) begin
          v[f] = 7'((e * 3 + f * 17 + d) & 127);
          wr(3'(f), {e[f], v[f]});
        end
        yv = 8'((e * 5 + d * 11) & 255);
        wr(3'd6, yv);
        wr(3'd7, {e[6], 7'h0});
        cal_sec  = v[0] ^ ((d == 0) ? 7'h1 : 7'h0);
        cal_min  = v[1] ^ ((d == 1) ? 7'h1 : 7'h0);
        cal_hour = v[2] ^ ((d == 2) ? 7'h1 : 7'h0);
        cal_wday = v[3] ^ ((d == 3) ? 7'h1 : 7'h0);
        cal_day  = v[4] ^ ((d == 4) ? 7'h1 : 7'h0);
        cal_mon  = v[5] ^ ((d == 5) ? 7'h1 : 7'h0);
        cal_year = yv   ^ ((d == 6) ? 8'h1 : 8'h0);
        exp = (e != 0) && ((d == 7) || !e[d]);
        if (e == 0) tag = "R10";
        else if (d < 7 && !e[d]) tag = "R2";
        else tag = "R1";
        do_tick(1'b0);
        check(tag, {31'h0, irq_flag}, {31'h0, exp});
      end
    end

    // Binary sweep: varied masks vs. one flipped counter bit (R3, R4, R10)
    mode = 1'b1;
    for (int mi = 0; mi < 39; mi++) begin
      if (mi < 32) msk = 32'h1 << mi;
      else if (mi == 32) msk = 32'h0;
      else if (mi < 37) msk = 32'hFF << (8 * (mi - 33));
      else if (mi == 37) msk = 32'hFFFF_FFFF;
      else msk = 32'hA5A5_5A5A;
      alm = 32'h3C96_E10F ^ (32'(mi) * 32'h0101_0101);
      for (int j = 0; j < 33; j++) begin
        swr_clr();
        for (int b = 0; b < 4; b++) begin
          wr(3'(b), alm[b*8 +: 8]);
          wr(3'(4 + b), msk[b*8 +: 8]);
        end
        bin_cnt = alm ^ ((j < 32) ? (32'h1 << j) : 32'h0);
        exp = (msk != 0) && ((j == 32) || !msk[j]);
        if (msk == 0) tag = "R10";
        else if (j < 32 && !msk[j]) tag = "R4";
        else tag = "R3";
        do_tick(1'b0);
        check(tag, {31'h0, irq_flag}, {31'h0, exp});
      end
    end

    // R5: address 7 = year enable (calendar) or mask bits 31..24 (binary)
    swr_clr();
    wr(3'd3, 8'h80); wr(3'd6, 8'h00); wr(3'd7, 8'h80);
    mode = 1'b0; cal_wday = 7'h00; cal_year = 8'h00; bin_cnt = 32'h0;
    do_tick(1'b0);
    check("R5", {31'h0, irq_flag}, 32'h1);
    clr();
    mode = 1'b1;
    do_tick(1'b0);
    check("R5", {31'h0, irq_flag}, 32'h0);
    bin_cnt = 32'h8000_0000;
    do_tick(1'b0);
    check("R5", {31'h0, irq_flag}, 32'h1);
    clr();
    mode = 1'b0; cal_year = 8'h01;
    do_tick(1'b0);
    check("R5", {31'h0, irq_flag}, 32'h0);

    // R12: matching count without tick leaves flag low
    swr_clr();
    mode = 1'b0;
    wr(3'd0, 8'h85); cal_sec = 7'd5;
    idle(5);
    check("R12", {31'h0, irq_flag}, 32'h0);
    do_tick(1'b0);
    check("R12", {31'h0, irq_flag}, 32'h1);

    // R8: held match does not re-set after a clear; re-arms after a break
    do_tick(1'b0);
    clr();
    check("R8", {31'h0, irq_flag}, 32'h0);
    do_tick(1'b0);
    do_tick(1'b0);
    check("R8", {31'h0, irq_flag}, 32'h0);
    cal_sec = 7'd6;
    do_tick(1'b0);
    check("R8", {31'h0, irq_flag}, 32'h0);
    cal_sec = 7'd5;
    do_tick(1'b0);
    check("R8", {31'h0, irq_flag}, 32'h1);

    // R9: sticky, clear, and set wins over a simultaneous clear
    idle(5);
    check("R9", {31'h0, irq_flag}, 32'h1);
    clr();
    check("R9", {31'h0, irq_flag}, 32'h0);
    cal_sec = 7'd6;
    do_tick(1'b0);
    cal_sec = 7'd5;
    do_tick(1'b1);
    check("R9", {31'h0, irq_flag}, 32'h1);
    clr();
    check("R9", {31'h0, irq_flag}, 32'h0);

    finish_run();
  end
endmodule